// File: doc/BRIEF.md
# Microcoded Multicycle Control Sequencer

This block is the control unit of a multicycle processor that shares one memory and one ALU between all steps of an instruction. A micro-address register selects one word of a small control store. Each word is a compact encoded microinstruction of 15 bits, split into fields for the ALU operation, the two ALU operand sources, the register-file write destination, the memory access, the instruction-register load, the program-counter update and the sequencing choice. Per-field decoders turn the word into the individual control lines that drive the datapath.

The sequencing field picks the next micro-address in one of three ways: return to the fetch word at address 0, advance to the current address plus one, or jump through an opcode-indexed dispatch table. The control program covers instruction fetch, decode, register-register arithmetic, OR with an immediate, load word, store word and branch-on-equal. An opcode outside that set dispatches straight back to fetch. The control lines are combinational functions of the micro-address, so they are valid for the whole cycle in which that address is held.

Top module: `mcode_ctrl`

## Requirements
- R1: While `rst_n` is low the micro-address is 0 and the fetch control lines are driven; the first cycle after release is the fetch word.
- R2: A word whose sequencing is "next" (addresses 0, 4, 6, 8, 9, 11) is followed on the next clock edge by the address one higher.
- R3: A word whose sequencing is "fetch" (addresses 2, 5, 7, 10, 12) is followed by address 0; cycle counts per instruction from fetch back to fetch are 4 (register op), 3 (branch), 4 (OR-immediate), 5 (load), 4 (store).
- R4: At address 1 the next address comes from the opcode: 0x00 gives 4, 0x04 gives 2, 0x0D gives 6, 0x23 gives 8, 0x2B gives 11.
- R5: Any other opcode at address 1 gives next address 0 (two-cycle instruction); the opcode has no effect on sequencing at any other address.
- R6: Address 0 drives `alu_fn`=00 (add; 01 subtract, 10 function code, 11 OR), `opa_sel`=0 (PC; 1 is rs), `opb_sel`=00 (constant 4; 01 rt, 10 shifted immediate, 11 immediate), memory read at the PC, instruction load and an unconditional PC load from the ALU; all other lines low.
- R7: Address 1 drives add of PC and the sign-extended shifted immediate (`opb_sel`=10, `imm_signed`=1), nothing else.
- R8: Address 2 drives subtract of rs and rt with a conditional PC load sourced from the ALU output register, nothing else.
- R9: Addresses 4/6 drive function-code op on rs,rt and OR of rs with the zero-extended immediate (`opb_sel`=11, `imm_signed`=0); addresses 5/7 write rd resp. rt from the ALU (`rf_we`=1, `rf_dst_rd`=1 resp. 0, `rf_wdata_mem`=0).
- R10: Load: address 8 adds rs and the sign-extended immediate, 9 reads memory at the ALU output, 10 writes rt from memory.
- R11: Store: address 11 adds rs and the sign-extended immediate, 12 writes memory at the ALU output.
- R12: Memory read and write are never both active, the two PC load lines are never both active, and the memory write-back select is only set with a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | OP_W (6) | Opcode field of the instruction register |
| uaddr | output | UADDR_W (4) | Current micro-address |
| alu_fn | output | 2 | ALU operation select |
| opa_sel | output | 1 | First ALU operand: 0 PC, 1 rs |
| opb_sel | output | 2 | Second ALU operand select |
| imm_signed | output | 1 | Immediate sign-extends when 1, zero-extends when 0 |
| rf_we | output | 1 | Register file write enable |
| rf_wdata_mem | output | 1 | Register write data from memory when 1, from ALU when 0 |
| rf_dst_rd | output | 1 | Register destination rd when 1, rt when 0 |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| mem_addr_alu | output | 1 | Memory address from ALU output register when 1, PC when 0 |
| instr_ld | output | 1 | Instruction register load |
| pc_ld | output | 1 | Unconditional PC load |
| pc_ld_if_zero | output | 1 | PC load when the ALU result is zero |
| pc_from_aluout | output | 1 | PC source is the ALU output register when 1, ALU when 0 |

## Verification
On every cycle the assertions check the sequencing rules (advance by one, return to fetch, dispatch hits and misses), the fetch-word and branch-word control lines, the store write address and the mutual exclusion of the memory and PC controls. Only the bench's scenarios show the complete decoded control vector at each reachable address, the per-opcode micro-address trace and cycle count, that random opcode values outside the dispatch cycle leave the trace unchanged, and that a reset asserted mid-instruction returns the sequencer to fetch.

// File: rtl/mcode_pkg.sv
package mcode_pkg;

   localparam int OPC_BITS = 6;

   // sequencing codes
   localparam logic [1:0] SEQ_FETCH    = 2'b00;
   localparam logic [1:0] SEQ_DISPATCH = 2'b01;
   localparam logic [1:0] SEQ_NEXT     = 2'b10;

   // ALU field
   localparam logic [1:0] ALU_ADD  = 2'b00;
   localparam logic [1:0] ALU_SUB  = 2'b01;
   localparam logic [1:0] ALU_FUNC = 2'b10;
   localparam logic [1:0] ALU_OR   = 2'b11;

   // first operand field
   localparam logic A_PC = 1'b0;
   localparam logic A_RS = 1'b1;

   // second operand field
   localparam logic [2:0] B_NONE   = 3'b000;
   localparam logic [2:0] B_FOUR   = 3'b001;
   localparam logic [2:0] B_RT     = 3'b010;
   localparam logic [2:0] B_IMM_SH = 3'b011;
   localparam logic [2:0] B_IMM_SX = 3'b100;
   localparam logic [2:0] B_IMM_ZX = 3'b111;

   // register write-back field
   localparam logic [1:0] DST_NONE   = 2'b00;
   localparam logic [1:0] DST_RD_ALU = 2'b01;
   localparam logic [1:0] DST_RT_ALU = 2'b10;
   localparam logic [1:0] DST_RT_MEM = 2'b11;

   // memory field
   localparam logic [1:0] MEM_NONE   = 2'b00;
   localparam logic [1:0] MEM_RD_PC  = 2'b01;
   localparam logic [1:0] MEM_RD_ALU = 2'b10;
   localparam logic [1:0] MEM_WR_ALU = 2'b11;

   // PC update field
   localparam logic [1:0] PCW_NONE = 2'b00;
   localparam logic [1:0] PCW_ALU  = 2'b01;
   localparam logic [1:0] PCW_COND = 2'b10;

   // opcodes handled by the dispatch table
   localparam logic [OPC_BITS-1:0] OPC_RTYPE = 6'h00;
   localparam logic [OPC_BITS-1:0] OPC_BEQ   = 6'h04;
   localparam logic [OPC_BITS-1:0] OPC_ORI   = 6'h0D;
   localparam logic [OPC_BITS-1:0] OPC_LW    = 6'h23;
   localparam logic [OPC_BITS-1:0] OPC_SW    = 6'h2B;

   // micro-addresses of the control program
   localparam int UA_FETCH  = 0;
   localparam int UA_DECODE = 1;
   localparam int UA_BEQ    = 2;
   localparam int UA_RTYPE  = 4;
   localparam int UA_ORI    = 6;
   localparam int UA_LW     = 8;
   localparam int UA_SW     = 11;
   localparam int UA_LAST   = 12;

   localparam int DISP_N = 5;
   localparam logic [OPC_BITS-1:0] DISP_OPC [DISP_N] =
      '{OPC_RTYPE, OPC_BEQ, OPC_ORI, OPC_LW, OPC_SW};
   localparam int DISP_TGT [DISP_N] =
      '{UA_RTYPE, UA_BEQ, UA_ORI, UA_LW, UA_SW};

   typedef struct packed {
      logic [1:0] alu;
      logic       src1;
      logic [2:0] src2;
      logic [1:0] dest;
      logic [1:0] mem;
      logic       ir;
      logic [1:0] pcw;
      logic [1:0] seq;
   } uword_t;

   localparam int UWORD_W = $bits(uword_t);

   typedef struct packed {
      logic [1:0] alu_fn;
      logic       opa_sel;
      logic [1:0] opb_sel;
      logic       imm_signed;
      logic       rf_we;
      logic       rf_wdata_mem;
      logic       rf_dst_rd;
      logic       mem_rd;
      logic       mem_wr;
      logic       mem_addr_alu;
      logic       instr_ld;
      logic       pc_ld;
      logic       pc_ld_if_zero;
      logic       pc_from_aluout;
   } ctrl_t;

   function automatic uword_t mk_word(
      input logic [1:0] alu, input logic src1, input logic [2:0] src2,
      input logic [1:0] dest, input logic [1:0] mem, input logic ir,
      input logic [1:0] pcw, input logic [1:0] seq);
      uword_t w;
      w.alu  = alu;
      w.src1 = src1;
      w.src2 = src2;
      w.dest = dest;
      w.mem  = mem;
      w.ir   = ir;
      w.pcw  = pcw;
      w.seq  = seq;
      return w;
   endfunction

endpackage

// File: rtl/mcode_store.sv
module mcode_store
   import mcode_pkg::*;
#(
   parameter int UADDR_W = 4
) (
   input  logic [UADDR_W-1:0] addr,
   output uword_t             word
);

   localparam int LOW_W = 4;

   logic in_range;

   generate
      if (UADDR_W > LOW_W) begin : g_wide
         assign in_range = ~|addr[UADDR_W-1:LOW_W];
      end else begin : g_exact
         assign in_range = 1'b1;
      end
   endgenerate

   always_comb begin
      word = '0;
      if (in_range) begin
         case (addr[LOW_W-1:0])
            4'd0:  word = mk_word(ALU_ADD,  A_PC, B_FOUR,   DST_NONE,   MEM_RD_PC,  1'b1, PCW_ALU,  SEQ_NEXT);
            4'd1:  word = mk_word(ALU_ADD,  A_PC, B_IMM_SH, DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_DISPATCH);
            4'd2:  word = mk_word(ALU_SUB,  A_RS, B_RT,     DST_NONE,   MEM_NONE,   1'b0, PCW_COND, SEQ_FETCH);
            4'd4:  word = mk_word(ALU_FUNC, A_RS, B_RT,     DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
            4'd5:  word = mk_word(ALU_ADD,  A_PC, B_NONE,   DST_RD_ALU, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH);
            4'd6:  word = mk_word(ALU_OR,   A_RS, B_IMM_ZX, DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
            4'd7:  word = mk_word(ALU_ADD,  A_PC, B_NONE,   DST_RT_ALU, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH);
            4'd8:  word = mk_word(ALU_ADD,  A_RS, B_IMM_SX, DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
            4'd9:  word = mk_word(ALU_ADD,  A_PC, B_NONE,   DST_NONE,   MEM_RD_ALU, 1'b0, PCW_NONE, SEQ_NEXT);
            4'd10: word = mk_word(ALU_ADD,  A_PC, B_NONE,   DST_RT_MEM, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH);
            4'd11: word = mk_word(ALU_ADD,  A_RS, B_IMM_SX, DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
            4'd12: word = mk_word(ALU_ADD,  A_PC, B_NONE,   DST_NONE,   MEM_WR_ALU, 1'b0, PCW_NONE, SEQ_FETCH);
            default: word = '0;
         endcase
      end
   end

endmodule

// File: rtl/mcode_dispatch.sv
module mcode_dispatch
   import mcode_pkg::*;
#(
   parameter int OP_W      = 6,
   parameter int UADDR_W   = 4,
   parameter int TABLE_IMPL = 0
) (
   input  logic [OP_W-1:0]    opcode,
   output logic [UADDR_W-1:0] target
);

   generate
      if (TABLE_IMPL == 0) begin : g_case
         always_comb begin
            case (opcode)
               OPC_RTYPE: target = UADDR_W'(UA_RTYPE);
               OPC_BEQ:   target = UADDR_W'(UA_BEQ);
               OPC_ORI:   target = UADDR_W'(UA_ORI);
               OPC_LW:    target = UADDR_W'(UA_LW);
               OPC_SW:    target = UADDR_W'(UA_SW);
               default:   target = UADDR_W'(UA_FETCH);
            endcase
         end
      end else begin : g_scan
         always_comb begin
            target = UADDR_W'(UA_FETCH);
            for (int i = 0; i < DISP_N; i++) begin
               if (opcode == DISP_OPC[i]) target = UADDR_W'(DISP_TGT[i]);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mcode_field_dec.sv
module mcode_field_dec
   import mcode_pkg::*;
(
   input  uword_t w,
   output ctrl_t  c
);

   always_comb begin
      c = '0;

      c.alu_fn   = w.alu;
      c.opa_sel  = w.src1;
      c.instr_ld = w.ir;

      case (w.src2)
         B_FOUR:   begin c.opb_sel = 2'b00; c.imm_signed = 1'b0; end
         B_RT:     begin c.opb_sel = 2'b01; c.imm_signed = 1'b0; end
         B_IMM_SH: begin c.opb_sel = 2'b10; c.imm_signed = 1'b1; end
         B_IMM_SX: begin c.opb_sel = 2'b11; c.imm_signed = 1'b1; end
         B_IMM_ZX: begin c.opb_sel = 2'b11; c.imm_signed = 1'b0; end
         default:  begin c.opb_sel = 2'b00; c.imm_signed = 1'b0; end
      endcase

      case (w.dest)
         DST_RD_ALU: begin c.rf_we = 1'b1; c.rf_wdata_mem = 1'b0; c.rf_dst_rd = 1'b1; end
         DST_RT_ALU: begin c.rf_we = 1'b1; c.rf_wdata_mem = 1'b0; c.rf_dst_rd = 1'b0; end
         DST_RT_MEM: begin c.rf_we = 1'b1; c.rf_wdata_mem = 1'b1; c.rf_dst_rd = 1'b0; end
         default:    begin c.rf_we = 1'b0; c.rf_wdata_mem = 1'b0; c.rf_dst_rd = 1'b0; end
      endcase

      case (w.mem)
         MEM_RD_PC:  begin c.mem_rd = 1'b1; c.mem_wr = 1'b0; c.mem_addr_alu = 1'b0; end
         MEM_RD_ALU: begin c.mem_rd = 1'b1; c.mem_wr = 1'b0; c.mem_addr_alu = 1'b1; end
         MEM_WR_ALU: begin c.mem_rd = 1'b0; c.mem_wr = 1'b1; c.mem_addr_alu = 1'b1; end
         default:    begin c.mem_rd = 1'b0; c.mem_wr = 1'b0; c.mem_addr_alu = 1'b0; end
      endcase

      case (w.pcw)
         PCW_ALU:  begin c.pc_ld = 1'b1; c.pc_ld_if_zero = 1'b0; c.pc_from_aluout = 1'b0; end
         PCW_COND: begin c.pc_ld = 1'b0; c.pc_ld_if_zero = 1'b1; c.pc_from_aluout = 1'b1; end
         default:  begin c.pc_ld = 1'b0; c.pc_ld_if_zero = 1'b0; c.pc_from_aluout = 1'b0; end
      endcase
   end

endmodule

// File: rtl/mcode_upc.sv
module mcode_upc
   import mcode_pkg::*;
#(
   parameter int UADDR_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         seq,
   input  logic [UADDR_W-1:0] disp_addr,
   output logic [UADDR_W-1:0] upc
);

   logic [UADDR_W-1:0] upc_nxt;

   always_comb begin
      case (seq)
         SEQ_NEXT:     upc_nxt = upc + UADDR_W'(1);
         SEQ_DISPATCH: upc_nxt = disp_addr;
         default:      upc_nxt = UADDR_W'(UA_FETCH);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc <= UADDR_W'(UA_FETCH);
      else        upc <= upc_nxt;
   end

endmodule

// File: rtl/mcode_ctrl.sv
module mcode_ctrl
   import mcode_pkg::*;
#(
   parameter int UADDR_W    = 4,
   parameter int OP_W       = 6,
   parameter int TABLE_IMPL = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [OP_W-1:0]    opcode,
   output logic [UADDR_W-1:0] uaddr,
   output logic [1:0]         alu_fn,
   output logic               opa_sel,
   output logic [1:0]         opb_sel,
   output logic               imm_signed,
   output logic               rf_we,
   output logic               rf_wdata_mem,
   output logic               rf_dst_rd,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic               mem_addr_alu,
   output logic               instr_ld,
   output logic               pc_ld,
   output logic               pc_ld_if_zero,
   output logic               pc_from_aluout
);

   generate
      if (UADDR_W < 4) begin : g_bad_uaddr
         $error("mcode_ctrl: UADDR_W must be at least 4");
      end
      if (OP_W != OPC_BITS) begin : g_bad_op
         $error("mcode_ctrl: OP_W must equal the opcode field width");
      end
      if (TABLE_IMPL < 0 || TABLE_IMPL > 1) begin : g_bad_impl
         $error("mcode_ctrl: TABLE_IMPL must be 0 or 1");
      end
   endgenerate

   uword_t             word;
   ctrl_t              ctl;
   logic [1:0]         seq_sel;
   logic [UADDR_W-1:0] disp_addr;

   mcode_upc #(.UADDR_W(UADDR_W)) u_upc (
      .clk       (clk),
      .rst_n     (rst_n),
      .seq       (seq_sel),
      .disp_addr (disp_addr),
      .upc       (uaddr)
   );

   mcode_store #(.UADDR_W(UADDR_W)) u_store (
      .addr (uaddr),
      .word (word)
   );

   mcode_dispatch #(.OP_W(OP_W), .UADDR_W(UADDR_W), .TABLE_IMPL(TABLE_IMPL)) u_disp (
      .opcode (opcode),
      .target (disp_addr)
   );

   mcode_field_dec u_dec (
      .w (word),
      .c (ctl)
   );

   assign seq_sel        = word.seq;
   assign alu_fn         = ctl.alu_fn;
   assign opa_sel        = ctl.opa_sel;
   assign opb_sel        = ctl.opb_sel;
   assign imm_signed     = ctl.imm_signed;
   assign rf_we          = ctl.rf_we;
   assign rf_wdata_mem   = ctl.rf_wdata_mem;
   assign rf_dst_rd      = ctl.rf_dst_rd;
   assign mem_rd         = ctl.mem_rd;
   assign mem_wr         = ctl.mem_wr;
   assign mem_addr_alu   = ctl.mem_addr_alu;
   assign instr_ld       = ctl.instr_ld;
   assign pc_ld          = ctl.pc_ld;
   assign pc_ld_if_zero  = ctl.pc_ld_if_zero;
   assign pc_from_aluout = ctl.pc_from_aluout;

endmodule

// File: rtl/mcode_ctrl_chk.sv
module mcode_ctrl_chk
   import mcode_pkg::*;
#(
   parameter int UADDR_W = 4,
   parameter int OP_W    = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic [OP_W-1:0]    opcode,
   input logic [1:0]         seq,
   input logic [UADDR_W-1:0] uaddr,
   input logic [1:0]         alu_fn,
   input logic [1:0]         opb_sel,
   input logic               rf_we,
   input logic               rf_wdata_mem,
   input logic               mem_rd,
   input logic               mem_wr,
   input logic               mem_addr_alu,
   input logic               instr_ld,
   input logic               pc_ld,
   input logic               pc_ld_if_zero,
   input logic               pc_from_aluout
);

   function automatic int known_target(input logic [OP_W-1:0] op);
      if (op == 6'h00) return 4;
      if (op == 6'h04) return 2;
      if (op == 6'h0D) return 6;
      if (op == 6'h23) return 8;
      if (op == 6'h2B) return 11;
      return -1;
   endfunction

   p_reset_r1: assert property (@(posedge clk)
      !rst_n |-> (uaddr == '0 && pc_ld && instr_ld && mem_rd));

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seq == SEQ_NEXT |=> uaddr == $past(uaddr) + UADDR_W'(1));

   p_refetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      seq == SEQ_FETCH |=> uaddr == '0);

   p_disp_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (uaddr == UADDR_W'(1) && known_target(opcode) >= 0)
      |=> int'(uaddr) == known_target($past(opcode)));

   p_disp_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (uaddr == UADDR_W'(1) && known_target(opcode) < 0) |=> uaddr == '0);

   p_fetch_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      uaddr == '0 |-> (mem_rd && !mem_addr_alu && instr_ld && pc_ld &&
                       !pc_ld_if_zero && opb_sel == 2'b00 && alu_fn == 2'b00));

   p_branch_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pc_ld_if_zero |-> (uaddr == UADDR_W'(2) && alu_fn == 2'b01 &&
                         pc_from_aluout && !pc_ld));

   p_store_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_addr_alu && uaddr == UADDR_W'(12)));

   p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr) && !(pc_ld && pc_ld_if_zero) && (rf_we || !rf_wdata_mem));

endmodule

bind mcode_ctrl mcode_ctrl_chk #(.UADDR_W(UADDR_W), .OP_W(OP_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .opcode         (opcode),
   .seq            (seq_sel),
   .uaddr          (uaddr),
   .alu_fn         (alu_fn),
   .opb_sel        (opb_sel),
   .rf_we          (rf_we),
   .rf_wdata_mem   (rf_wdata_mem),
   .mem_rd         (mem_rd),
   .mem_wr         (mem_wr),
   .mem_addr_alu   (mem_addr_alu),
   .instr_ld       (instr_ld),
   .pc_ld          (pc_ld),
   .pc_ld_if_zero  (pc_ld_if_zero),
   .pc_from_aluout (pc_from_aluout)
);

// File: tb/tb_mcode_ctrl.sv
module tb_mcode_ctrl;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [5:0] opcode;
   logic [3:0] uaddr;
   logic [1:0] alu_fn, opb_sel;
   logic opa_sel, imm_signed, rf_we, rf_wdata_mem, rf_dst_rd;
   logic mem_rd, mem_wr, mem_addr_alu, instr_ld, pc_ld, pc_ld_if_zero, pc_from_aluout;

   int checks = 0;
   int failures = 0;
   int m_addr = 0;
   string trace_tag = "R1";
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcode_ctrl dut (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .uaddr(uaddr),
      .alu_fn(alu_fn), .opa_sel(opa_sel), .opb_sel(opb_sel), .imm_signed(imm_signed),
      .rf_we(rf_we), .rf_wdata_mem(rf_wdata_mem), .rf_dst_rd(rf_dst_rd),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr_alu(mem_addr_alu),
      .instr_ld(instr_ld), .pc_ld(pc_ld), .pc_ld_if_zero(pc_ld_if_zero),
      .pc_from_aluout(pc_from_aluout)
   );

   // bit order: alu_fn[15:14] opa 13 opb[12:11] imm 10 we 9 wmem 8 rd 7
   //            mrd 6 mwr 5 maddr 4 ir 3 pcld 2 pcz 1 pcsrc 0
   function automatic logic [15:0] ref_lines(input int a);
      logic [15:0] v = '0;
      case (a)
         0:  begin v[6] = 1; v[3] = 1; v[2] = 1; end
         1:  begin v[12:11] = 2'b10; v[10] = 1; end
         2:  begin v[15:14] = 2'b01; v[13] = 1; v[12:11] = 2'b01; v[1] = 1; v[0] = 1; end
         4:  begin v[15:14] = 2'b10; v[13] = 1; v[12:11] = 2'b01; end
         5:  begin v[9] = 1; v[7] = 1; end
         6:  begin v[15:14] = 2'b11; v[13] = 1; v[12:11] = 2'b11; end
         7:  begin v[9] = 1; end
         8, 11: begin v[13] = 1; v[12:11] = 2'b11; v[10] = 1; end
         9:  begin v[6] = 1; v[4] = 1; end
         10: begin v[9] = 1; v[8] = 1; end
         12: begin v[5] = 1; v[4] = 1; end
         default: v = '0;
      endcase
      return v;
   endfunction

   function automatic string line_tag(input int a);
      case (a)
         0: return "R6";
         1: return "R7";
         2: return "R8";
         4, 5, 6, 7: return "R9";
         8, 9, 10: return "R10";
         default: return "R11";
      endcase
   endfunction

   function automatic int ref_target(input logic [5:0] op);
      case (op)
         6'h00: return 4;
         6'h04: return 2;
         6'h0D: return 6;
         6'h23: return 8;
         6'h2B: return 11;
         default: return 0;
      endcase
   endfunction

   function automatic int ref_len(input logic [5:0] op);
      case (op)
         6'h00, 6'h0D, 6'h2B: return 4;
         6'h04: return 3;
         6'h23: return 5;
         default: return 2;
      endcase
   endfunction

   function automatic logic [15:0] dut_lines();
      return {alu_fn, opa_sel, opb_sel, imm_signed, rf_we, rf_wdata_mem, rf_dst_rd,
              mem_rd, mem_wr, mem_addr_alu, instr_ld, pc_ld, pc_ld_if_zero, pc_from_aluout};
   endfunction

   task automatic check_int(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic check_cycle();
      check_int(trace_tag, "micro-address", int'(uaddr), m_addr);
      checks++;
      if (dut_lines() !== ref_lines(m_addr)) begin
         failures++;
         $display("FAIL %s lines at uaddr %0d actual=%h expected=%h",
                  line_tag(m_addr), m_addr, dut_lines(), ref_lines(m_addr));
      end
   endtask

   // one instruction from fetch back to fetch; opcode is random except at decode
   task automatic run_instr(input logic [5:0] op);
      int len = 0;
      int nxt;
      do begin
         check_cycle();
         if (m_addr == 1) opcode = op;
         else             opcode = 6'($urandom);
         case (m_addr)
            1: begin
               nxt = ref_target(opcode);
               trace_tag = (nxt == 0) ? "R5" : "R4";
            end
            0, 4, 6, 8, 9, 11: begin nxt = m_addr + 1; trace_tag = "R2"; end
            default: begin nxt = 0; trace_tag = "R3"; end
         endcase
         @(negedge clk);
         m_addr = nxt;
         len++;
      end while (m_addr != 0 && len < 20);
      check_int("R3", $sformatf("cycle count for opcode %h", op), len, ref_len(op));
   endtask

   initial begin
      logic [5:0] prog [15] = '{6'h00, 6'h04, 6'h0D, 6'h23, 6'h2B, 6'h3F, 6'h02,
                               6'h23, 6'h2B, 6'h00, 6'h0D, 6'h04, 6'h01, 6'h2A, 6'h23};
      rst_n  = 1'b0;
      opcode = 6'h23;
      repeat (3) @(negedge clk);
      // R1: reset state
      m_addr = 0; trace_tag = "R1";
      check_cycle();
      rst_n = 1'b1;
      for (int i = 0; i < 15; i++) run_instr(prog[i]);
      // R1: reset in the middle of a load
      check_cycle();
      opcode = 6'h23;
      @(negedge clk);
      m_addr = 1;
      @(negedge clk);
      m_addr = 8;
      @(negedge clk);
      m_addr = 9;
      trace_tag = "R1";
      check_cycle();
      rst_n = 1'b0;
      #1;
      check_int("R1", "micro-address under reset", int'(uaddr), 0);
      @(negedge clk);
      m_addr = 0;
      check_cycle();
      rst_n = 1'b1;
      run_instr(6'h2B);
      run_instr(6'h15);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule